// File: doc/BRIEF.md
# Two-Driver Dot-Matrix Display Refresh Sequencer

This block refreshes a multiplexed dot-matrix vacuum fluorescent display that has two serial driver chips: one switches the grids and one switches the anodes. The time between refreshes is cut into equal slots, one per grid. The grid driver is never reloaded in full. A single high bit is fed into its serial input on the first grid clock of a refresh period. Each later slot boundary moves that bit one position along, and the grid latch input is held open so the shift register contents reach the grid outputs directly.

The anode driver is reloaded in every slot. While one slot is being displayed, the sequencer reads the pattern word of the next grid from a pattern store over a one-cycle-latency read port. It serialises that word into the anode driver, placing zero padding ahead of the pattern bits. On the next slot boundary the anode latch and the grid clock pulse in the same cycle, so the new anode pattern appears together with the newly selected grid. A blanking output is raised for a programmable number of clocks on each side of every boundary.

Top module: `vfd_refresh_seq`

## Requirements
- R1: While `rst` is high, every output is 0, including the pattern read strobe and the grid latch.
- R2: A slot lasts `SLOT_CLKS` clocks. `grid_clk` pulses high for exactly one clock per slot, and `grid_lat` stays high from the first clock after reset.
- R3: `grid_sin` is high around the grid clock of the first slot of each refresh period and low around every other grid clock. A grid driver that shifts toward higher outputs therefore has exactly one of its first `NUM_GRIDS` outputs high, and in the slot with 0-based index k within the period that output is output k+1.
- R4: Exactly one pattern read occurs per slot. During the slot with index k, `pat_rd_slot` equals (k+1) mod `NUM_GRIDS`. Data is taken from `pat_rd_data` one clock after `pat_rd_en`.
- R5: Each slot carries exactly `ANODE_LEN` rising edges of `anode_clk`. The `ANODE_LEN-PAT_BITS` zero padding bits go first, followed by pattern bit `PAT_BITS-1` down to bit 0. In a driver that shifts toward higher positions, pattern bit j therefore ends at position j and every padding position holds 0.
- R6: `anode_lat` pulses in exactly the same clocks as `grid_clk`.
- R7: The anode pattern shown in slot s is the word read during slot s-1. The first slot after reset shows all anodes off.
- R8: `anode_blank` is high for `BLANK_CLKS` clocks before and `BLANK_CLKS` clocks after each slot boundary, giving a run of 2*`BLANK_CLKS` clocks that contains every grid clock, anode latch and `grid_sin` pulse. The first run after reset lasts `BLANK_CLKS` clocks.
- R9: `anode_clk` rests low outside the shift window and never coincides with `anode_lat`. `anode_sin` stays constant while `anode_clk` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst | input | 1 | Synchronous active-high reset |
| pat_rd_en | output | 1 | Pattern store read strobe |
| pat_rd_slot | output | $clog2(NUM_GRIDS) | Grid index of the pattern word requested |
| pat_rd_data | input | PAT_BITS | Pattern word, valid one clock after the strobe |
| grid_sin | output | 1 | Serial data into the grid driver |
| grid_clk | output | 1 | Grid driver shift clock |
| grid_lat | output | 1 | Grid driver latch enable, held open |
| anode_sin | output | 1 | Serial data into the anode driver |
| anode_clk | output | 1 | Anode driver shift clock |
| anode_lat | output | 1 | Anode driver latch pulse |
| anode_blank | output | 1 | Display blanking around slot boundaries |

## Verification
The hardest condition to reach is the wrap of a refresh period. The last slot must fetch the word for grid 1 while a fresh start bit enters the grid driver, and the stale bit from the previous period has to leave the first twenty outputs. The bench runs more than two full periods back to back, modelling both driver chips at the pins, and rewrites pattern words at random while they are in flight so that any off-by-one in the fetch index shows up. A reset in the middle of an anode shift window then checks that the sequence restarts with a dark first slot and grid 1.

// File: rtl/vfd_seq_pkg.sv
package vfd_seq_pkg;

    // slot-relative cycle positions of the fixed events
    localparam int unsigned STEP_AT    = 1;  // grid clock + anode latch
    localparam int unsigned GS_LAST    = 2;  // last cycle of the grid start window
    localparam int unsigned FETCH_AT   = 2;  // pattern read request
    localparam int unsigned CAPTURE_AT = 4;  // pattern word lands in frame
    localparam int unsigned SHIFT_AT   = 5;  // first serial cycle

    typedef struct packed {
        logic gs_win;
        logic step;
    } grid_evt_t;

    typedef struct packed {
        logic step;
        logic fetch;
        logic capture;
        logic shift_on;
        logic shift_hi;
        logic blank;
    } anode_evt_t;

    typedef struct packed {
        logic sin;
        logic clk;
        logic lat;
    } drv_pins_t;

    function automatic int unsigned wrap_next(input int unsigned idx, input int unsigned n);
        return (idx + 1 >= n) ? 0 : idx + 1;
    endfunction

    function automatic logic in_span(input int unsigned c, input int unsigned lo, input int unsigned hi);
        return (c >= lo) && (c < hi);
    endfunction

endpackage

// File: rtl/vfd_slot_timer.sv
module vfd_slot_timer
    import vfd_seq_pkg::*;
#(
    parameter int unsigned NUM_GRIDS  = 20,
    parameter int unsigned ANODE_LEN  = 96,
    parameter int unsigned SLOT_CLKS  = 256,
    parameter int unsigned BLANK_CLKS = 8,
    parameter int unsigned SW         = 5
) (
    input  logic            clk,
    input  logic            rst,
    output grid_evt_t       g_evt,
    output anode_evt_t      a_evt,
    output logic [SW-1:0]   fetch_idx
);
    localparam int unsigned CNT_W     = $clog2(SLOT_CLKS);
    localparam int unsigned SHIFT_END = SHIFT_AT + 2 * ANODE_LEN;
    localparam int unsigned BLANK_HI  = SLOT_CLKS - BLANK_CLKS;

    logic [CNT_W-1:0] cnt;
    logic [SW-1:0]    disp;
    logic             wrap;

    assign wrap      = (cnt == CNT_W'(SLOT_CLKS - 1));
    assign fetch_idx = SW'(wrap_next(32'(disp), NUM_GRIDS));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            disp <= '0;
        end else if (wrap) begin
            cnt  <= '0;
            disp <= fetch_idx;
        end else begin
            cnt  <= cnt + CNT_W'(1);
        end
    end

    always_comb begin
        int unsigned c;
        c = 32'(cnt);
        g_evt.gs_win   = (disp == '0) && (c <= GS_LAST);
        g_evt.step     = (c == STEP_AT);
        a_evt.step     = (c == STEP_AT);
        a_evt.fetch    = (c == FETCH_AT);
        a_evt.capture  = (c == CAPTURE_AT);
        a_evt.shift_on = in_span(c, SHIFT_AT, SHIFT_END);
        a_evt.shift_hi = a_evt.shift_on && (((c - SHIFT_AT) & 32'd1) != 0);
        a_evt.blank    = (c < BLANK_CLKS) || (c >= BLANK_HI);
    end

endmodule

// File: rtl/vfd_grid_scan.sv
module vfd_grid_scan
    import vfd_seq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  grid_evt_t g_evt,
    output logic      grid_sin,
    output logic      grid_clk,
    output logic      grid_lat
);
    drv_pins_t q;

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q.sin <= g_evt.gs_win;
            q.clk <= g_evt.step;
            q.lat <= 1'b1;
        end
    end

    assign grid_sin = q.sin;
    assign grid_clk = q.clk;
    assign grid_lat = q.lat;

endmodule

// File: rtl/vfd_anode_loader.sv
module vfd_anode_loader
    import vfd_seq_pkg::*;
#(
    parameter int unsigned PAT_BITS  = 72,
    parameter int unsigned ANODE_LEN = 96,
    parameter int unsigned SW        = 5
) (
    input  logic                clk,
    input  logic                rst,
    input  anode_evt_t          a_evt,
    input  logic [SW-1:0]       fetch_idx,
    input  logic [PAT_BITS-1:0] pat_rd_data,
    output logic                pat_rd_en,
    output logic [SW-1:0]       pat_rd_slot,
    output logic                anode_sin,
    output logic                anode_clk,
    output logic                anode_lat,
    output logic                anode_blank
);
    logic [ANODE_LEN-1:0] padded;
    logic [ANODE_LEN-1:0] frame;
    drv_pins_t            q;
    logic                 blank_q;

    generate
        if (ANODE_LEN > PAT_BITS) begin : g_pad
            assign padded = {{(ANODE_LEN - PAT_BITS){1'b0}}, pat_rd_data};
        end else begin : g_trim
            assign padded = pat_rd_data[ANODE_LEN-1:0];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            pat_rd_en   <= 1'b0;
            pat_rd_slot <= '0;
            frame       <= '0;
            q           <= '0;
            blank_q     <= 1'b0;
        end else begin
            pat_rd_en <= a_evt.fetch;
            if (a_evt.fetch) begin
                pat_rd_slot <= fetch_idx;
            end
            if (a_evt.capture) begin
                frame <= padded;
            end else if (a_evt.shift_hi) begin
                frame <= {frame[ANODE_LEN-2:0], 1'b0};
            end
            if (a_evt.shift_on && !a_evt.shift_hi) begin
                q.sin <= frame[ANODE_LEN-1];
            end
            q.clk   <= a_evt.shift_hi;
            q.lat   <= a_evt.step;
            blank_q <= a_evt.blank;
        end
    end

    assign anode_sin   = q.sin;
    assign anode_clk   = q.clk;
    assign anode_lat   = q.lat;
    assign anode_blank = blank_q;

endmodule

// File: rtl/vfd_refresh_seq.sv
module vfd_refresh_seq
    import vfd_seq_pkg::*;
#(
    parameter int unsigned NUM_GRIDS  = 20,
    parameter int unsigned PAT_BITS   = 72,
    parameter int unsigned ANODE_LEN  = 96,
    parameter int unsigned SLOT_CLKS  = 256,
    parameter int unsigned BLANK_CLKS = 8,
    localparam int unsigned SW        = $clog2(NUM_GRIDS)
) (
    input  logic                clk,
    input  logic                rst,
    output logic                pat_rd_en,
    output logic [SW-1:0]       pat_rd_slot,
    input  logic [PAT_BITS-1:0] pat_rd_data,
    output logic                grid_sin,
    output logic                grid_clk,
    output logic                grid_lat,
    output logic                anode_sin,
    output logic                anode_clk,
    output logic                anode_lat,
    output logic                anode_blank
);
    grid_evt_t     g_evt;
    anode_evt_t    a_evt;
    logic [SW-1:0] fetch_idx;

    vfd_slot_timer #(
        .NUM_GRIDS (NUM_GRIDS),
        .ANODE_LEN (ANODE_LEN),
        .SLOT_CLKS (SLOT_CLKS),
        .BLANK_CLKS(BLANK_CLKS),
        .SW        (SW)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .g_evt    (g_evt),
        .a_evt    (a_evt),
        .fetch_idx(fetch_idx)
    );

    vfd_grid_scan u_grid (
        .clk     (clk),
        .rst     (rst),
        .g_evt   (g_evt),
        .grid_sin(grid_sin),
        .grid_clk(grid_clk),
        .grid_lat(grid_lat)
    );

    vfd_anode_loader #(
        .PAT_BITS (PAT_BITS),
        .ANODE_LEN(ANODE_LEN),
        .SW       (SW)
    ) u_anode (
        .clk        (clk),
        .rst        (rst),
        .a_evt      (a_evt),
        .fetch_idx  (fetch_idx),
        .pat_rd_data(pat_rd_data),
        .pat_rd_en  (pat_rd_en),
        .pat_rd_slot(pat_rd_slot),
        .anode_sin  (anode_sin),
        .anode_clk  (anode_clk),
        .anode_lat  (anode_lat),
        .anode_blank(anode_blank)
    );

endmodule

// File: rtl/vfd_refresh_seq_chk.sv
module vfd_refresh_seq_chk #(
    parameter int unsigned NUM_GRIDS = 20,
    parameter int unsigned SW        = 5
) (
    input logic          clk,
    input logic          rst,
    input logic          pat_rd_en,
    input logic [SW-1:0] pat_rd_slot,
    input logic          grid_sin,
    input logic          grid_clk,
    input logic          grid_lat,
    input logic          anode_sin,
    input logic          anode_clk,
    input logic          anode_lat,
    input logic          anode_blank
);
    a_r2_gclk_single: assert property (@(posedge clk) disable iff (rst)
        grid_clk |=> !grid_clk);

    a_r2_glat_held: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> grid_lat);

    a_r3_gsin_inside_blank: assert property (@(posedge clk) disable iff (rst)
        grid_sin |-> anode_blank);

    a_r4_read_pulse: assert property (@(posedge clk) disable iff (rst)
        pat_rd_en |=> !pat_rd_en);

    a_r4_slot_range: assert property (@(posedge clk) disable iff (rst)
        pat_rd_en |-> (pat_rd_slot < NUM_GRIDS));

    a_r6_lat_with_gclk: assert property (@(posedge clk) disable iff (rst)
        grid_clk |-> anode_lat);

    a_r6_gclk_with_lat: assert property (@(posedge clk) disable iff (rst)
        anode_lat |-> grid_clk);

    a_r8_blank_at_step: assert property (@(posedge clk) disable iff (rst)
        (grid_clk || anode_lat) |-> anode_blank);

    a_r9_sin_steady: assert property (@(posedge clk) disable iff (rst)
        anode_clk |-> $stable(anode_sin));

    a_r9_clk_off_at_latch: assert property (@(posedge clk) disable iff (rst)
        anode_clk |-> !anode_lat);

endmodule

bind vfd_refresh_seq vfd_refresh_seq_chk #(
    .NUM_GRIDS(NUM_GRIDS),
    .SW       (SW)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .pat_rd_en  (pat_rd_en),
    .pat_rd_slot(pat_rd_slot),
    .grid_sin   (grid_sin),
    .grid_clk   (grid_clk),
    .grid_lat   (grid_lat),
    .anode_sin  (anode_sin),
    .anode_clk  (anode_clk),
    .anode_lat  (anode_lat),
    .anode_blank(anode_blank)
);

// File: tb/test_vfd_refresh_seq.sv
module test_vfd_refresh_seq;
    localparam int NG = 20;
    localparam int PB = 72;
    localparam int AL = 96;
    localparam int SC = 256;
    localparam int BC = 8;
    localparam int GL = 96;
    localparam int SW = $clog2(NG);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          pat_rd_en;
    logic [SW-1:0] pat_rd_slot;
    logic [PB-1:0] pat_rd_data = '0;
    logic          grid_sin, grid_clk, grid_lat;
    logic          anode_sin, anode_clk, anode_lat, anode_blank;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    logic [PB-1:0] mem [NG];

    vfd_refresh_seq #(
        .NUM_GRIDS(NG), .PAT_BITS(PB), .ANODE_LEN(AL),
        .SLOT_CLKS(SC), .BLANK_CLKS(BC)
    ) i_vfd_refresh_seq (
        .clk(clk), .rst(rst),
        .pat_rd_en(pat_rd_en), .pat_rd_slot(pat_rd_slot), .pat_rd_data(pat_rd_data),
        .grid_sin(grid_sin), .grid_clk(grid_clk), .grid_lat(grid_lat),
        .anode_sin(anode_sin), .anode_clk(anode_clk), .anode_lat(anode_lat),
        .anode_blank(anode_blank)
    );

    always #2 clk = ~clk;

    // pattern store with one clock of read latency
    always @(posedge clk) if (pat_rd_en) pat_rd_data <= mem[pat_rd_slot];

    // pin-level models of the two driver chips
    logic [GL-1:0] gm;
    logic [AL-1:0] am, al;
    always @(posedge grid_clk or posedge rst)
        if (rst) gm <= '0; else gm <= {gm[GL-2:0], grid_sin};
    always @(posedge anode_clk or posedge rst)
        if (rst) am <= '0; else am <= {am[AL-2:0], anode_sin};
    always @(posedge anode_lat or posedge rst)
        if (rst) al <= '0; else al <= am;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [95:0] act, input logic [95:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [95:0] grid_expect(input int s);
        logic [95:0] v;
        v = '0;
        v[s % NG] = 1'b1;
        return v;
    endfunction

    int s_cur, since, clk_n, rd_n, run, last_run;
    bit prev_aclk;
    logic [PB-1:0] exp_next, shown;

    always @(negedge clk) begin
        if (rst) begin
            s_cur = -1; since = -1; clk_n = 0; rd_n = 0; run = 0; last_run = 0;
            prev_aclk = 0; exp_next = '0; shown = '0;
        end else begin
            if (anode_clk && !prev_aclk) clk_n++;
            prev_aclk = anode_clk;
            if (anode_blank) run++;
            else if (run != 0) begin last_run = run; run = 0; end
            if (anode_lat) begin
                if (s_cur >= 0) begin
                    check(clk_n == AL, "R5", "anode clocks in slot", 96'(clk_n), 96'(AL));
                    check(rd_n == 1, "R4", "reads in slot", 96'(rd_n), 96'd1);
                    check(since == SC - 1, "R2", "slot length", 96'(since + 1), 96'(SC));
                end
                check(grid_clk == 1'b1, "R6", "grid clock with latch", 96'(grid_clk), 96'd1);
                s_cur++;
                shown = exp_next;  // R7: word of previous slot, zero for the first
                clk_n = 0; rd_n = 0; since = 0;
            end else if (since >= 0) begin
                since++;
            end
            if (pat_rd_en) begin
                rd_n++;
                check(int'(pat_rd_slot) == (s_cur + 1) % NG, "R4", "fetch index",
                      96'(pat_rd_slot), 96'((s_cur + 1) % NG));
                exp_next = mem[pat_rd_slot];
            end
            if (since == 10) begin
                check(gm[NG-1:0] == grid_expect(s_cur)[NG-1:0], "R3", "active grid",
                      96'(gm[NG-1:0]), grid_expect(s_cur));
                check(al[PB-1:0] == shown, "R7", "displayed anodes", 96'(al[PB-1:0]), 96'(shown));
                check(al[AL-1:PB] == '0, "R5", "padding positions", 96'(al[AL-1:PB]), 96'd0);
                check(grid_lat == 1'b1, "R2", "grid latch open", 96'(grid_lat), 96'd1);
                check(last_run == ((s_cur == 0) ? BC : 2 * BC), "R8", "blank run",
                      96'(last_run), 96'((s_cur == 0) ? BC : 2 * BC));
                check(anode_clk == 1'b0 && anode_blank == 1'b0, "R9", "idle clock after blank",
                      96'({anode_clk, anode_blank}), 96'd0);
            end
        end
    end

    task automatic check_reset_state();
        logic [7:0] o;
        o = {pat_rd_en, grid_sin, grid_clk, grid_lat, anode_sin, anode_clk, anode_lat, anode_blank};
        check(o == 8'd0, "R1", "outputs in reset", 96'(o), 96'd0);
    endtask

    task automatic run_slots(input int n);
        for (int k = 0; k < n; k++) begin
            logic [95:0] r;
            do @(negedge clk); while (!anode_lat);
            repeat (20) @(negedge clk);
            r = {$urandom(), $urandom(), $urandom()};
            case (k % 7)
                3: mem[(s_cur + 4) % NG] = '1;
                5: mem[(s_cur + 4) % NG] = '0;
                default: mem[(s_cur + 4) % NG] = r[PB-1:0];
            endcase
        end
    endtask

    initial begin
        void'($urandom(32'd4711));
        for (int i = 0; i < NG; i++) begin
            logic [95:0] r;
            r = {$urandom(), $urandom(), $urandom()};
            mem[i] = r[PB-1:0];
        end
        mem[0]  = '1;                          // every anode on
        mem[1]  = '0;                          // every anode off
        mem[2]  = {(PB/2){2'b01}};             // alternating
        mem[3]  = PB'(1);                      // only pattern bit 0
        mem[NG-1] = {1'b1, {(PB-1){1'b0}}};    // only top pattern bit, wrap slot

        rst = 1'b1;
        repeat (4) @(negedge clk);
        check_reset_state();
        rst = 1'b0;
        run_slots(45);                         // more than two refresh periods

        repeat (37) @(negedge clk);            // inside an anode shift window
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check_reset_state();
        rst = 1'b0;
        run_slots(24);
        repeat (20) @(negedge clk);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL R2 watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule